// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block keeps the interrupt state of a single processor across 256 vectors. It holds three 256-bit bit-maps, each organised as 32-bit words: pending requests, vectors in service, and a trigger-mode map that records whether each vector was accepted as level or edge. Requests come from a delivery port that carries a vector number and a level/edge flag. The block finds the highest pending vector and compares its priority class (the upper nibble) with a processor priority. That processor priority is formed from a task-priority byte and the highest vector in service.

The processor sees a registered interrupt line. It takes a vector through a one-cycle acknowledge strobe, and the answer appears in the same cycle. It retires the current handler with an end-of-interrupt strobe. If a pending request is held back by priority when the acknowledge arrives, the block returns a programmable spurious vector. Retiring a level-triggered vector emits a one-cycle broadcast that carries the vector number, so the upstream source can re-arm.

A software-enable bit gates the whole block. The task priority can be written as a full byte, or through a narrow 4-bit control path that holds only the priority class.

Top module: `lipc_top`

## Requirements
- R1: After reset, `irq_out`, `ppr_out`, `tpr_rdata`, `cr_rdata` and `bc_valid` are all zero. The control register resets to 0xFF, so the block starts disabled with spurious vector 0xFF.
- R2: An accepted vector sets its pending bit. If `acc_level` is 1 it also sets the vector's trigger-mode bit; if 0 it clears it. A later end-of-interrupt for that vector broadcasts only if the bit is set.
- R3: Among pending vectors, the highest-numbered one is selected first.
- R4: `ppr_out` is defined as follows:
  - It equals the task-priority byte when the task class (bits 7:4) is greater than or equal to the class of the highest in-service vector.
  - Otherwise it equals that in-service class followed by four zero bits.
  - An empty in-service map counts as vector 0.
- R5: A pending vector is deliverable only when `ppr_out` is zero or the vector's class (bits 7:4) is strictly greater than the class in `ppr_out`. An equal class is blocked.
- R6: An acknowledge with a deliverable vector has four effects:
  - it returns that vector with `ack_hit`=1 and `ack_spur`=0;
  - it clears the vector's pending bit;
  - it sets the vector's in-service bit;
  - it thereby raises `ppr_out` when the vector's class exceeds the task class.
- R7: An acknowledge while a request is pending but blocked returns control-register bits 7:0 with `ack_hit`=1 and `ack_spur`=1, and changes no state. An acknowledge with nothing pending gives `ack_hit`=0 and `ack_vec`=0.
- R8: An end-of-interrupt clears the highest in-service bit. If that vector's trigger-mode bit is set, the next cycle carries `bc_valid`=1 with `bc_vec` equal to the vector. Only bits 8:0 of a control write are kept, so a directed-EOI request in bit 12 is dropped and the broadcast still occurs.
- R9: An end-of-interrupt with no in-service bit set changes nothing: it emits no broadcast and leaves `ppr_out` unchanged.
- R10: While control bit 8 (enable) is 0, `irq_out` stays low and an acknowledge returns `ack_hit`=0.
- R11: A task-priority byte write stores the byte as given. A control-path write of value v stores v<<4. `cr_rdata` reads task-priority bits 7:4. If both writes arrive in the same cycle, the byte write wins.
- R12: If an accept and a deliverable acknowledge of the same vector arrive in the same cycle, the acknowledge returns and services the vector, and the accept wins for the pending bit, which stays set.
- R13: `irq_out` is registered. It equals enable AND deliverable, evaluated on the state of the previous cycle, so it changes one clock after the state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accept strobe for a delivered vector |
| acc_vec | input | 8 | Vector being delivered |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | One-cycle acknowledge strobe from the processor |
| ack_hit | output | 1 | Acknowledge returned a vector (real or spurious) |
| ack_spur | output | 1 | Returned vector is the spurious vector |
| ack_vec | output | 8 | Vector returned on acknowledge |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task-priority byte write |
| tpr_wdata | input | 8 | Task-priority byte |
| tpr_rdata | output | 8 | Current task-priority byte |
| cr_wr | input | 1 | Control-path priority-class write |
| cr_wdata | input | 4 | Priority class to store in bits 7:4 |
| cr_rdata | output | 4 | Task-priority bits 7:4 |
| svr_wr | input | 1 | Control register write |
| svr_wdata | input | 32 | Control word (bit 8 enable, bits 7:0 spurious vector) |
| ppr_out | output | 8 | Current processor priority |
| irq_out | output | 1 | Registered interrupt request to the processor |
| bc_valid | output | 1 | End-of-interrupt broadcast pulse |
| bc_vec | output | 8 | Vector carried by the broadcast |

## Verification
Two collisions are exercised, both in a single clock.

- **Accept and acknowledge of the same vector.** The bench drives `acc_valid` and `ack_req` together, with the vector already pending. The acknowledge must return the vector. A second acknowledge must then come back spurious, since the class now equals the processor priority. After an end-of-interrupt, a third acknowledge must return the vector again, which proves the pending bit survived.
- **Acknowledge during retirement.** An acknowledge that lands while a higher vector is still in service must return the spurious vector. The scoreboard compares every acknowledge answer and every broadcast pulse, in order, against its expectation queues.

// File: rtl/lipc_pkg.sv
package lipc_pkg;
   // outcome of an acknowledge cycle
   typedef enum logic [1:0] {
      ACK_NONE = 2'd0,
      ACK_VEC  = 2'd1,
      ACK_SPUR = 2'd2
   } ack_res_e;

   localparam int unsigned LIPC_WORD_W = 32;
endpackage

// File: rtl/lipc_hifind.sv
// Highest-set-bit finder over a wide map, built word by word.
module lipc_hifind #(
   parameter int unsigned W      = 256,
   parameter int unsigned WORD_W = lipc_pkg::LIPC_WORD_W,
   localparam int unsigned IDX_W = $clog2(W),
   localparam int unsigned BIT_W = $clog2(WORD_W),
   localparam int unsigned NWORD = W / WORD_W
) (
   input  logic [W-1:0]     map_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   if (W % WORD_W != 0) begin : g_bad_w
      $error("lipc_hifind: W must be a multiple of WORD_W");
   end

   logic [NWORD-1:0] wany;
   logic [BIT_W-1:0] widx [NWORD];

   for (genvar w = 0; w < NWORD; w++) begin : g_word
      always_comb begin
         wany[w] = |map_i[w*WORD_W +: WORD_W];
         widx[w] = '0;
         for (int b = 0; b < WORD_W; b++) begin
            if (map_i[w*WORD_W + b]) widx[w] = BIT_W'(b);
         end
      end
   end

   always_comb begin
      any_o = |wany;
      idx_o = '0;
      for (int w = 0; w < NWORD; w++) begin
         if (wany[w]) idx_o = IDX_W'(w * WORD_W) | IDX_W'(widx[w]);
      end
   end
endmodule

// File: rtl/lipc_bitmap.sv
// One vector-wide state map with set-wins-over-clear update.
module lipc_bitmap #(
   parameter int unsigned W = 256
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/lipc_prio.sv
// Processor priority and deliverability decision.
module lipc_prio #(
   parameter int unsigned VEC_W = 8,
   parameter int unsigned CLS_W = 4
) (
   input  logic [VEC_W-1:0] tpr_i,
   input  logic             isr_any_i,
   input  logic [VEC_W-1:0] isr_top_i,
   input  logic             irr_any_i,
   input  logic [VEC_W-1:0] irr_top_i,
   output logic [VEC_W-1:0] ppr_o,
   output logic             deliver_o
);
   if (CLS_W > VEC_W) begin : g_bad_cls
      $error("lipc_prio: CLS_W must not exceed VEC_W");
   end

   logic [CLS_W-1:0] isr_cls, tpr_cls, irr_cls, ppr_cls;

   always_comb begin
      isr_cls   = isr_any_i ? isr_top_i[VEC_W-1 -: CLS_W] : '0;
      tpr_cls   = tpr_i[VEC_W-1 -: CLS_W];
      irr_cls   = irr_top_i[VEC_W-1 -: CLS_W];
      ppr_o     = (tpr_cls >= isr_cls) ? tpr_i
                                       : {isr_cls, {(VEC_W-CLS_W){1'b0}}};
      ppr_cls   = ppr_o[VEC_W-1 -: CLS_W];
      deliver_o = irr_any_i && ((ppr_o == '0) || (irr_cls > ppr_cls));
   end
endmodule

// File: rtl/lipc_top.sv
module lipc_top #(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned CLS_W     = 4,
   parameter int unsigned SVR_BUS_W = 32,
   parameter int unsigned SVR_W     = 9,
   parameter int unsigned EN_BIT    = 8,
   parameter int unsigned DEOI_BIT  = 12,
   parameter logic [SVR_W-1:0] SVR_RST = SVR_W'(8'hFF)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic [VEC_W-1:0]     acc_vec,
   input  logic                 acc_level,
   input  logic                 ack_req,
   output logic                 ack_hit,
   output logic                 ack_spur,
   output logic [VEC_W-1:0]     ack_vec,
   input  logic                 eoi_wr,
   input  logic                 tpr_wr,
   input  logic [VEC_W-1:0]     tpr_wdata,
   output logic [VEC_W-1:0]     tpr_rdata,
   input  logic                 cr_wr,
   input  logic [CLS_W-1:0]     cr_wdata,
   output logic [CLS_W-1:0]     cr_rdata,
   input  logic                 svr_wr,
   input  logic [SVR_BUS_W-1:0] svr_wdata,
   output logic [VEC_W-1:0]     ppr_out,
   output logic                 irq_out,
   output logic                 bc_valid,
   output logic [VEC_W-1:0]     bc_vec
);
   import lipc_pkg::*;

   localparam int unsigned NVEC = 1 << VEC_W;

   if (SVR_W < VEC_W + 1 || EN_BIT >= SVR_W) begin : g_bad_svr
      $error("lipc_top: control register too narrow for vector and enable");
   end
   if (SVR_W > SVR_BUS_W) begin : g_bad_bus
      $error("lipc_top: control register wider than its write bus");
   end

   // ---------------- state ----------------
   logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
   logic [NVEC-1:0]  irr_set, irr_clr, isr_set, isr_clr, tmr_set, tmr_clr;
   logic [SVR_W-1:0] svr_q;
   logic [VEC_W-1:0] tpr_q;
   logic             irq_q, bc_v_q;
   logic [VEC_W-1:0] bc_vec_q;

   // ---------------- search and priority ----------------
   logic             irr_any, isr_any, deliver;
   logic [VEC_W-1:0] irr_top, isr_top;

   lipc_hifind #(.W(NVEC)) u_irr_find (.map_i(irr_q), .any_o(irr_any), .idx_o(irr_top));
   lipc_hifind #(.W(NVEC)) u_isr_find (.map_i(isr_q), .any_o(isr_any), .idx_o(isr_top));

   lipc_prio #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_prio (
      .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_top_i(isr_top),
      .irr_any_i(irr_any), .irr_top_i(irr_top),
      .ppr_o(ppr_out), .deliver_o(deliver)
   );

   // ---------------- control register variants ----------------
   logic enabled, directed;
   assign enabled = svr_q[EN_BIT];

   if (DEOI_BIT < SVR_W) begin : g_deoi_kept
      assign directed = svr_q[DEOI_BIT];
   end else begin : g_deoi_dropped
      assign directed = 1'b0;
   end

   // ---------------- acknowledge decode ----------------
   ack_res_e ack_res;
   logic     ack_take, eoi_do;

   always_comb begin
      if (!ack_req || !enabled || !irr_any) ack_res = ACK_NONE;
      else if (deliver)                     ack_res = ACK_VEC;
      else                                  ack_res = ACK_SPUR;
   end

   assign ack_take = (ack_res == ACK_VEC);
   assign ack_hit  = (ack_res != ACK_NONE);
   assign ack_spur = (ack_res == ACK_SPUR);

   always_comb begin
      unique case (ack_res)
         ACK_VEC:  ack_vec = irr_top;
         ACK_SPUR: ack_vec = svr_q[VEC_W-1:0];
         default:  ack_vec = '0;
      endcase
   end

   assign eoi_do = eoi_wr && isr_any;

   // ---------------- map update masks ----------------
   logic [NVEC-1:0] acc_oh, ack_oh, eoi_oh;

   always_comb begin
      acc_oh  = acc_valid ? (NVEC'(1) << acc_vec) : '0;
      ack_oh  = ack_take  ? (NVEC'(1) << irr_top) : '0;
      eoi_oh  = eoi_do    ? (NVEC'(1) << isr_top) : '0;
      irr_set = acc_oh;
      irr_clr = ack_oh;
      isr_set = ack_oh;
      isr_clr = eoi_oh;
      tmr_set = acc_level ? acc_oh : '0;
      tmr_clr = acc_level ? '0 : acc_oh;
   end

   lipc_bitmap #(.W(NVEC)) u_irr (.clk(clk), .rst_n(rst_n), .set_i(irr_set), .clr_i(irr_clr), .q_o(irr_q));
   lipc_bitmap #(.W(NVEC)) u_isr (.clk(clk), .rst_n(rst_n), .set_i(isr_set), .clr_i(isr_clr), .q_o(isr_q));
   lipc_bitmap #(.W(NVEC)) u_tmr (.clk(clk), .rst_n(rst_n), .set_i(tmr_set), .clr_i(tmr_clr), .q_o(tmr_q));

   // ---------------- scalar registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         svr_q    <= SVR_RST;
         tpr_q    <= '0;
         irq_q    <= 1'b0;
         bc_v_q   <= 1'b0;
         bc_vec_q <= '0;
      end else begin
         if (svr_wr) svr_q <= svr_wdata[SVR_W-1:0];
         if (tpr_wr)     tpr_q <= tpr_wdata;
         else if (cr_wr) tpr_q <= {cr_wdata, {(VEC_W-CLS_W){1'b0}}};
         irq_q    <= enabled && deliver;
         bc_v_q   <= eoi_do && tmr_q[isr_top] && !directed;
         bc_vec_q <= eoi_do ? isr_top : '0;
      end
   end

   assign irq_out   = irq_q;
   assign bc_valid  = bc_v_q;
   assign bc_vec    = bc_vec_q;
   assign tpr_rdata = tpr_q;
   assign cr_rdata  = tpr_q[VEC_W-1 -: CLS_W];
endmodule

// File: rtl/lipc_chk.sv
module lipc_chk #(
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned CLS_W  = 4,
   parameter int unsigned SVR_W  = 9,
   parameter int unsigned EN_BIT = 8,
   localparam int unsigned NVEC  = 1 << VEC_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic [VEC_W-1:0] acc_vec,
   input logic             acc_level,
   input logic             ack_req,
   input logic             ack_hit,
   input logic             ack_spur,
   input logic [VEC_W-1:0] ack_vec,
   input logic             eoi_wr,
   input logic [VEC_W-1:0] ppr_out,
   input logic             irq_out,
   input logic             bc_valid,
   input logic [NVEC-1:0]  irr_q,
   input logic [NVEC-1:0]  isr_q,
   input logic [NVEC-1:0]  tmr_q,
   input logic [SVR_W-1:0] svr_q
);
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> irr_q[$past(acc_vec)] && (tmr_q[$past(acc_vec)] == $past(acc_level)));

   p_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !ack_spur && ppr_out != '0)
         |-> ack_vec[VEC_W-1 -: CLS_W] > ppr_out[VEC_W-1 -: CLS_W]);

   p_take_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !ack_spur) |=> isr_q[$past(ack_vec)]);

   p_take_irr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !ack_spur && !(acc_valid && acc_vec == ack_vec)) |=> !irr_q[$past(ack_vec)]);

   p_spur_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_spur |-> (ack_hit && ack_vec == svr_q[VEC_W-1:0]));

   p_bc_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid |-> $past(eoi_wr));

   p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && isr_q == '0) |=> !bc_valid);

   p_irq_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(svr_q[EN_BIT]));

   p_ack_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !svr_q[EN_BIT]) |-> !ack_hit);
endmodule

bind lipc_top lipc_chk #(
   .VEC_W(VEC_W), .CLS_W(CLS_W), .SVR_W(SVR_W), .EN_BIT(EN_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vec(acc_vec),
   .acc_level(acc_level), .ack_req(ack_req), .ack_hit(ack_hit),
   .ack_spur(ack_spur), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
   .ppr_out(ppr_out), .irq_out(irq_out), .bc_valid(bc_valid),
   .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q), .svr_q(svr_q)
);

// File: tb/sim_lipc_top.sv
`timescale 1ns/1ps
module sim_lipc_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 0, acc_level = 0, ack_req = 0, eoi_wr = 0;
   logic [7:0] acc_vec = 0, tpr_wdata = 0;
   logic       tpr_wr = 0, cr_wr = 0, svr_wr = 0;
   logic [3:0] cr_wdata = 0;
   logic [31:0] svr_wdata = 0;
   logic       ack_hit, ack_spur, irq_out, bc_valid;
   logic [7:0] ack_vec, tpr_rdata, ppr_out, bc_vec;
   logic [3:0] cr_rdata;

   int checks = 0;
   int errors = 0;
   bit ended  = 0;

   logic [9:0] ack_exp_q [$];
   string      ack_tag_q [$];
   logic [7:0] bc_exp_q  [$];
   string      bc_tag_q  [$];

   always #2 clk = ~clk;

   lipc_top u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vec(acc_vec),
      .acc_level(acc_level), .ack_req(ack_req), .ack_hit(ack_hit),
      .ack_spur(ack_spur), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
      .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .tpr_rdata(tpr_rdata),
      .cr_wr(cr_wr), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
      .svr_wr(svr_wr), .svr_wdata(svr_wdata), .ppr_out(ppr_out),
      .irq_out(irq_out), .bc_valid(bc_valid), .bc_vec(bc_vec)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: sample late in the cycle, away from the rising edge
   always @(negedge clk) begin
      #1;
      if (rst_n && ack_req) begin
         if (ack_exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL ack unexpected actual=%0h expected=none", {ack_hit, ack_spur, ack_vec});
         end else begin
            automatic logic [9:0] e = ack_exp_q.pop_front();
            automatic string t = ack_tag_q.pop_front();
            chk(t, {22'd0, ack_hit, ack_spur, ack_vec}, {22'd0, e});
         end
      end
      if (rst_n && bc_valid) begin
         if (bc_exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 unexpected broadcast actual=%0h expected=none", bc_vec);
         end else begin
            automatic logic [7:0] e = bc_exp_q.pop_front();
            automatic string t = bc_tag_q.pop_front();
            chk(t, {24'd0, bc_vec}, {24'd0, e});
         end
      end
   end

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic accept(input logic [7:0] v, input logic lvl);
      @(negedge clk); acc_valid = 1; acc_vec = v; acc_level = lvl;
      @(negedge clk); acc_valid = 0;
   endtask

   task automatic ack(input logic hit, input logic spur, input logic [7:0] v, input string tag);
      ack_exp_q.push_back({hit, spur, v}); ack_tag_q.push_back(tag);
      @(negedge clk); ack_req = 1;
      @(negedge clk); ack_req = 0;
   endtask

   task automatic acc_ack(input logic [7:0] v, input logic lvl, input logic [7:0] exp_v, input string tag);
      ack_exp_q.push_back({2'b10, exp_v}); ack_tag_q.push_back(tag);
      @(negedge clk); acc_valid = 1; acc_vec = v; acc_level = lvl; ack_req = 1;
      @(negedge clk); acc_valid = 0; ack_req = 0;
   endtask

   task automatic eoi(input logic bc, input logic [7:0] v, input string tag);
      if (bc) begin bc_exp_q.push_back(v); bc_tag_q.push_back(tag); end
      @(negedge clk); eoi_wr = 1;
      @(negedge clk); eoi_wr = 0;
      @(negedge clk);
   endtask

   task automatic wr_tpr(input logic [7:0] v);
      @(negedge clk); tpr_wr = 1; tpr_wdata = v;
      @(negedge clk); tpr_wr = 0;
   endtask

   task automatic wr_cr(input logic [3:0] v);
      @(negedge clk); cr_wr = 1; cr_wdata = v;
      @(negedge clk); cr_wr = 0;
   endtask

   task automatic wr_svr(input logic [31:0] v);
      @(negedge clk); svr_wr = 1; svr_wdata = v;
      @(negedge clk); svr_wr = 0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         checks++;
         if (ack_exp_q.size() != 0 || bc_exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 leftover expectations actual=%0d expected=0",
                     ack_exp_q.size() + bc_exp_q.size());
         end
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      // R1: reset state
      chk("R1 irq", irq_out, 0);
      chk("R1 ppr", ppr_out, 0);
      chk("R1 tpr", tpr_rdata, 0);
      chk("R1 cr", cr_rdata, 0);
      chk("R1 bc", bc_valid, 0);

      // R10: disabled block
      accept(8'h40, 0);
      cyc(); cyc();
      chk("R10 irq while disabled", irq_out, 0);
      ack(0, 0, 8'h00, "R10 ack while disabled");

      // enable, spurious 0x3F, bit 12 set (dropped)
      wr_svr(32'h0000_113F);
      chk("R13 irq lags one cycle", irq_out, 0);
      cyc();
      chk("R13 irq after state", irq_out, 1);

      accept(8'h85, 1);
      accept(8'h41, 0);
      ack(1, 0, 8'h85, "R3 highest first");
      chk("R4 ppr from in-service", ppr_out, 8'h80);
      ack(1, 1, 8'h3F, "R7 blocked returns spurious");
      cyc();
      chk("R5 irq low when blocked", irq_out, 0);
      eoi(1, 8'h85, "R8 level broadcast despite bit12");
      chk("R8 ppr after eoi", ppr_out, 8'h00);

      wr_tpr(8'h45);
      chk("R4 ppr equals tpr", ppr_out, 8'h45);
      cyc();
      chk("R5 equal class blocks irq", irq_out, 0);
      ack(1, 1, 8'h3F, "R5 equal class blocked");

      wr_cr(4'h3);
      chk("R11 cr shifts", tpr_rdata, 8'h30);
      chk("R11 cr readback", cr_rdata, 4'h3);
      cyc();
      chk("R13 irq after tpr drop", irq_out, 1);
      ack(1, 0, 8'h41, "R6 deliver 41");
      chk("R6 ppr raised", ppr_out, 8'h40);
      ack(1, 1, 8'h3F, "R5 40 blocked by in-service 41");
      eoi(0, 8'h00, "R2 edge no broadcast");
      chk("R8 ppr back to tpr", ppr_out, 8'h30);
      ack(1, 0, 8'h40, "R6 deliver 40");
      eoi(0, 8'h00, "R2 edge no broadcast");

      // R9: empty in-service
      eoi(0, 8'h00, "R9 empty eoi");
      chk("R9 ppr unchanged", ppr_out, 8'h30);
      ack(0, 0, 8'h00, "R7 nothing pending");

      // R12: simultaneous accept and acknowledge
      accept(8'h90, 0);
      acc_ack(8'h90, 1, 8'h90, "R12 ack returns vector");
      chk("R12 ppr", ppr_out, 8'h90);
      ack(1, 1, 8'h3F, "R12 pending kept but blocked");
      eoi(1, 8'h90, "R12 level from accept");
      ack(1, 0, 8'h90, "R12 still pending");
      eoi(1, 8'h90, "R2 level broadcast");

      // R5: ppr zero lets class 0 through
      wr_cr(4'h0);
      accept(8'h05, 0);
      ack(1, 0, 8'h05, "R5 ppr zero delivers class 0");
      chk("R4 ppr zero with class 0 in service", ppr_out, 8'h00);
      eoi(0, 8'h00, "R2 edge no broadcast");

      // R11: byte write and class readback; byte wins over cr
      @(negedge clk); tpr_wr = 1; tpr_wdata = 8'hA7; cr_wr = 1; cr_wdata = 4'h2;
      @(negedge clk); tpr_wr = 0; cr_wr = 0;
      chk("R11 byte wins", tpr_rdata, 8'hA7);
      chk("R11 class readback", cr_rdata, 4'hA);

      // R10: disabling drops irq
      accept(8'hF0, 0);
      cyc();
      chk("R13 irq for F0", irq_out, 1);
      wr_svr(32'h0000_00FF);
      cyc();
      chk("R10 irq dropped", irq_out, 0);
      ack(0, 0, 8'h00, "R10 ack ignored");

      repeat (4) cyc();
      finish_run();
   end
endmodule